// File: doc/BRIEF.md
# Encoded Microcode Sequencer

This block is the control engine of a single-bus, multi-cycle processor datapath. A 6-bit micro-program counter addresses a fixed control store. Each word of the store carries 16 datapath control lines and a 3-bit jump type instead of a full next address. Jump logic forms the next micro-PC from that jump type, the decoded 5-bit opcode group, the memory busy flag and the datapath condition flag.

The stored routines cover instruction fetch, register-register ALU, register-immediate ALU, load word, jump-and-link, conditional branch and a memory-to-memory add. Jump types are: advance (0), wait-on-busy (1), return to fetch (2), dispatch by opcode (3), return to fetch if condition true (4) and return to fetch if condition false (5). The codes 6 and 7 act as return to fetch. A halt check in the jump logic overrides all of these in the trap step. An opcode with no routine sends the sequencer to that trap step, where it stops and raises an error output until reset.

Top module: `ucode_seq`

## Requirements
- R1: While rst_ni is low and after its release, upc_o is 0, trap_o is 0 and ctrl_o shows the first fetch word 16'h6800 (bits 14, 13 and 11: address load, A load and register drive with selector PC).
- R2: A step whose jump type is advance moves upc_o to upc_o+1 on the next clock, whatever busy_i and cond_i are.
- R3: A wait-on-busy step holds upc_o for every clock that busy_i is high, and advances by one on the first clock with busy_i low. busy_i has no effect on any other step.
- R4: Fetch runs steps 0, 1, 2. Step 1 waits on busy. Step 2 dispatches on opcode_i: 5'b01100 goes to step 3, 5'b00100 to 6, 5'b00000 to 9, 5'b11011 to 14, 5'b11000 to 17 and 5'b00010 to 23.
- R5: The register ALU routine runs 3, 4, 5 and then returns to step 0. The immediate ALU routine runs 6, 7, 8 and then returns to step 0.
- R6: The load routine runs 9, 10, 11 and 12, waits on busy at 12, then runs 13 and returns to step 0.
- R7: The jump-and-link routine runs 14, 15, 16 and returns to step 0.
- R8: The branch routine runs 17, 18, 19. At step 19, cond_i low returns to step 0, and cond_i high continues through 20, 21, 22 and then back to 0. cond_i has no effect at other steps.
- R9: The memory-to-memory add routine runs 23 to 29. It waits on busy at 24, 26 and 28, then returns to step 0.
- R10: Any other opcode at dispatch leads to step 31. There trap_o is high and upc_o stays 31 whatever the inputs, until rst_ni goes low.
- R11: ctrl_o bit 15 loads the instruction register, bit 1 enables memory and bit 0 makes that access a write. Step 1 shows 16'h8002 and step 28 shows 16'h0013. At most one bus driver is active in any step: register read (bit 11), immediate (bit 7), ALU (bit 4) or memory read (bit 1 with bit 0 low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 5 | Opcode field of the instruction register |
| busy_i | input | 1 | Memory access still in progress |
| cond_i | input | 1 | Datapath comparison result |
| upc_o | output | 6 | Current micro-PC |
| ctrl_o | output | 16 | Datapath control lines of the current step |
| trap_o | output | 1 | Undefined opcode reached; sequencer halted |

## Verification
Both status flags reach the jump logic in every cycle, so busy and condition can be presented together. Only the one that the current step's jump type names may steer the micro-PC. The bench raises cond_i during each wait-on-busy step of the fetch and memory-add routines. It also raises busy_i during the dispatch step, the branch test step and the last steps of the jump-and-link routine. It then compares the micro-PC trace, step by step, against the routine addresses in the requirements. A trace that stalls or branches where the named flag does not apply shows that the wrong flag was decoded.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int UPC_W = 6;
  localparam int OP_W  = 5;

  typedef logic [2:0] jmp_t;
  localparam jmp_t J_NEXT     = 3'd0;
  localparam jmp_t J_SPIN     = 3'd1;
  localparam jmp_t J_FETCH    = 3'd2;
  localparam jmp_t J_DISPATCH = 3'd3;
  localparam jmp_t J_FTRUE    = 3'd4;
  localparam jmp_t J_FFALSE   = 3'd5;

  // register selector
  localparam logic [1:0] RS_PC = 2'd0, RS_R1 = 2'd1, RS_R2 = 2'd2, RS_RD = 2'd3;
  // immediate format
  localparam logic [1:0] IM_I = 2'd0, IM_J = 2'd1, IM_B = 2'd2;
  // ALU function
  localparam logic [1:0] AO_FUNC = 2'd0, AO_ADD = 2'd1, AO_DEC4 = 2'd2, AO_INC4 = 2'd3;

  typedef struct packed {
    logic       ir_ld;
    logic       ma_ld;
    logic       a_ld;
    logic       b_ld;
    logic       reg_en;
    logic       reg_wr;
    logic [1:0] reg_sel;
    logic       imm_en;
    logic [1:0] imm_sel;
    logic       alu_en;
    logic [1:0] alu_op;
    logic       mem_en;
    logic       mem_wr;
  } ctrl_t;

  // routine entry points
  localparam int A_FETCH = 0;
  localparam int A_ALU   = 3;
  localparam int A_ALUI  = 6;
  localparam int A_LW    = 9;
  localparam int A_JAL   = 14;
  localparam int A_BR    = 17;
  localparam int A_MMA   = 23;
  localparam int A_TRAP  = 31;

  localparam logic [OP_W-1:0] OPC_ALU  = 5'b01100;
  localparam logic [OP_W-1:0] OPC_ALUI = 5'b00100;
  localparam logic [OP_W-1:0] OPC_LW   = 5'b00000;
  localparam logic [OP_W-1:0] OPC_JAL  = 5'b11011;
  localparam logic [OP_W-1:0] OPC_BR   = 5'b11000;
  localparam logic [OP_W-1:0] OPC_MMA  = 5'b00010;
endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
#(
  parameter int UPC_W = useq_pkg::UPC_W
) (
  input  logic [UPC_W-1:0] upc_i,
  output ctrl_t            ctrl_o,
  output jmp_t             jmp_o
);
  always_comb begin
    int unsigned idx;
    ctrl_t c;
    jmp_t  j;
    idx = 32'(upc_i);
    c = '0;
    j = J_FETCH;
    case (idx)
      0:  begin c.reg_en = 1'b1; c.reg_sel = RS_PC; c.ma_ld = 1'b1; c.a_ld = 1'b1; j = J_NEXT; end
      1:  begin c.mem_en = 1'b1; c.ir_ld = 1'b1; j = J_SPIN; end
      2:  begin c.alu_en = 1'b1; c.alu_op = AO_INC4; c.reg_wr = 1'b1; c.reg_sel = RS_PC; j = J_DISPATCH; end
      // register ALU
      3:  begin c.reg_en = 1'b1; c.reg_sel = RS_R1; c.a_ld = 1'b1; j = J_NEXT; end
      4:  begin c.reg_en = 1'b1; c.reg_sel = RS_R2; c.b_ld = 1'b1; j = J_NEXT; end
      5:  begin c.alu_en = 1'b1; c.alu_op = AO_FUNC; c.reg_wr = 1'b1; c.reg_sel = RS_RD; j = J_FETCH; end
      // immediate ALU
      6:  begin c.reg_en = 1'b1; c.reg_sel = RS_R1; c.a_ld = 1'b1; j = J_NEXT; end
      7:  begin c.imm_en = 1'b1; c.imm_sel = IM_I; c.b_ld = 1'b1; j = J_NEXT; end
      8:  begin c.alu_en = 1'b1; c.alu_op = AO_FUNC; c.reg_wr = 1'b1; c.reg_sel = RS_RD; j = J_FETCH; end
      // load
      9:  begin c.reg_en = 1'b1; c.reg_sel = RS_R1; c.a_ld = 1'b1; j = J_NEXT; end
      10: begin c.imm_en = 1'b1; c.imm_sel = IM_I; c.b_ld = 1'b1; j = J_NEXT; end
      11: begin c.alu_en = 1'b1; c.alu_op = AO_ADD; c.ma_ld = 1'b1; j = J_NEXT; end
      12: begin c.mem_en = 1'b1; c.reg_wr = 1'b1; c.reg_sel = RS_RD; j = J_SPIN; end
      13: j = J_FETCH;
      // jump and link: A still holds the instruction address
      14: begin c.alu_en = 1'b1; c.alu_op = AO_INC4; c.reg_wr = 1'b1; c.reg_sel = RS_RD; j = J_NEXT; end
      15: begin c.imm_en = 1'b1; c.imm_sel = IM_J; c.b_ld = 1'b1; j = J_NEXT; end
      16: begin c.alu_en = 1'b1; c.alu_op = AO_ADD; c.reg_wr = 1'b1; c.reg_sel = RS_PC; j = J_FETCH; end
      // branch: compare while reloading A from PC
      17: begin c.reg_en = 1'b1; c.reg_sel = RS_R1; c.a_ld = 1'b1; j = J_NEXT; end
      18: begin c.reg_en = 1'b1; c.reg_sel = RS_R2; c.b_ld = 1'b1; j = J_NEXT; end
      19: begin c.reg_en = 1'b1; c.reg_sel = RS_PC; c.a_ld = 1'b1; c.alu_op = AO_FUNC; j = J_FFALSE; end
      20: begin c.alu_en = 1'b1; c.alu_op = AO_DEC4; c.a_ld = 1'b1; j = J_NEXT; end
      21: begin c.imm_en = 1'b1; c.imm_sel = IM_B; c.b_ld = 1'b1; j = J_NEXT; end
      22: begin c.alu_en = 1'b1; c.alu_op = AO_ADD; c.reg_wr = 1'b1; c.reg_sel = RS_PC; j = J_FETCH; end
      // memory-to-memory add
      23: begin c.reg_en = 1'b1; c.reg_sel = RS_R1; c.ma_ld = 1'b1; j = J_NEXT; end
      24: begin c.mem_en = 1'b1; c.a_ld = 1'b1; j = J_SPIN; end
      25: begin c.reg_en = 1'b1; c.reg_sel = RS_R2; c.ma_ld = 1'b1; j = J_NEXT; end
      26: begin c.mem_en = 1'b1; c.b_ld = 1'b1; j = J_SPIN; end
      27: begin c.reg_en = 1'b1; c.reg_sel = RS_RD; c.ma_ld = 1'b1; j = J_NEXT; end
      28: begin c.alu_en = 1'b1; c.alu_op = AO_FUNC; c.mem_en = 1'b1; c.mem_wr = 1'b1; j = J_SPIN; end
      29: j = J_FETCH;
      default: begin c = '0; j = J_FETCH; end
    endcase
    ctrl_o = c;
    jmp_o  = j;
  end
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int OP_W  = useq_pkg::OP_W,
  parameter int UPC_W = useq_pkg::UPC_W
) (
  input  logic [OP_W-1:0]  opcode_i,
  output logic [UPC_W-1:0] tgt_o,
  output logic             known_o
);
  always_comb begin
    known_o = 1'b1;
    case (opcode_i)
      OPC_ALU:  tgt_o = UPC_W'(A_ALU);
      OPC_ALUI: tgt_o = UPC_W'(A_ALUI);
      OPC_LW:   tgt_o = UPC_W'(A_LW);
      OPC_JAL:  tgt_o = UPC_W'(A_JAL);
      OPC_BR:   tgt_o = UPC_W'(A_BR);
      OPC_MMA:  tgt_o = UPC_W'(A_MMA);
      default: begin
        tgt_o   = UPC_W'(A_TRAP);
        known_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int UPC_W = useq_pkg::UPC_W
) (
  input  logic [UPC_W-1:0] upc_i,
  input  jmp_t             jmp_i,
  input  logic [UPC_W-1:0] disp_i,
  input  logic             busy_i,
  input  logic             cond_i,
  input  logic             halt_i,
  output logic [UPC_W-1:0] upc_o
);
  localparam logic [UPC_W-1:0] FETCH0 = UPC_W'(A_FETCH);

  logic [UPC_W-1:0] inc;
  assign inc = upc_i + UPC_W'(1);

  always_comb begin
    case (jmp_i)
      J_NEXT:     upc_o = inc;
      J_SPIN:     upc_o = busy_i ? upc_i : inc;
      J_DISPATCH: upc_o = disp_i;
      J_FTRUE:    upc_o = cond_i ? FETCH0 : inc;
      J_FFALSE:   upc_o = cond_i ? inc : FETCH0;
      default:    upc_o = FETCH0; // fetch and the two spare codes
    endcase
    if (halt_i) upc_o = upc_i;
  end
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
  import useq_pkg::*;
#(
  parameter int UPC_W = useq_pkg::UPC_W,
  parameter int OP_W  = useq_pkg::OP_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [OP_W-1:0]            opcode_i,
  input  logic                       busy_i,
  input  logic                       cond_i,
  output logic [UPC_W-1:0]           upc_o,
  output logic [$bits(ctrl_t)-1:0]   ctrl_o,
  output logic                       trap_o
);
  localparam logic [UPC_W-1:0] TRAP_UPC = UPC_W'(A_TRAP);

  logic [UPC_W-1:0] upc_q, upc_d, disp_tgt;
  logic             disp_known;
  ctrl_t            ctrl;
  jmp_t             jmp;

  useq_rom #(.UPC_W(UPC_W)) u_rom (
    .upc_i (upc_q),
    .ctrl_o(ctrl),
    .jmp_o (jmp)
  );

  useq_dispatch #(.OP_W(OP_W), .UPC_W(UPC_W)) u_disp (
    .opcode_i(opcode_i),
    .tgt_o   (disp_tgt),
    .known_o (disp_known)
  );

  useq_next #(.UPC_W(UPC_W)) u_next (
    .upc_i (upc_q),
    .jmp_i (jmp),
    .disp_i(disp_tgt),
    .busy_i(busy_i),
    .cond_i(cond_i),
    .halt_i(trap_o),
    .upc_o (upc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upc_q <= UPC_W'(A_FETCH);
    else         upc_q <= upc_d;
  end

  assign upc_o  = upc_q;
  assign ctrl_o = ctrl;
  assign trap_o = (upc_q == TRAP_UPC);

  assert_next_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jmp == J_NEXT && !trap_o) |=> upc_q == $past(upc_q) + UPC_W'(1));

  assert_spin_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jmp == J_SPIN && busy_i) |=> $stable(upc_q));

  assert_undef_trap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jmp == J_DISPATCH && !disp_known) |=> trap_o);

  assert_br_not_taken_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jmp == J_FFALSE && !cond_i && !trap_o) |=> upc_q == UPC_W'(A_FETCH));

  assert_trap_halt_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> trap_o && $stable(upc_q));

  assert_one_driver_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl.reg_en, ctrl.imm_en, ctrl.alu_en, ctrl.mem_en & ~ctrl.mem_wr}));
endmodule

// File: tb/sim_ucode_seq.sv
module sim_ucode_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] opcode_i = 5'b0;
  logic       busy_i = 1'b0;
  logic       cond_i = 1'b0;
  logic [5:0] upc_o;
  logic [15:0] ctrl_o;
  logic       trap_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  ucode_seq u0 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .opcode_i(opcode_i),
    .busy_i  (busy_i),
    .cond_i  (cond_i),
    .upc_o   (upc_o),
    .ctrl_o  (ctrl_o),
    .trap_o  (trap_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h) at %0t", req, act, act, exp, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic step_chk(input string req, input int exp);
    tick();
    chk(req, int'(upc_o), exp);
  endtask

  task automatic fetch_to_dispatch(input logic [4:0] opc);
    opcode_i = opc;
    busy_i = 1'b0;
    chk("R4 fetch start", int'(upc_o), 0);
    step_chk("R4 fetch1", 1);
    step_chk("R4 fetch2", 2);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    #3;
    chk("R1 upc in reset", int'(upc_o), 0);
    chk("R1 trap in reset", int'(trap_o), 0);
    repeat (2) tick();
    rst_ni = 1'b1;
    chk("R1 upc after release", int'(upc_o), 0);
    chk("R1 ctrl fetch0", int'(ctrl_o), 16'h6800);
  endtask

  task automatic t_alu();
    opcode_i = 5'b01100;
    step_chk("R2 next from 0", 1);
    chk("R11 ctrl fetch1", int'(ctrl_o), 16'h8002);
    step_chk("R4 fetch2", 2);
    step_chk("R4 dispatch alu", 3);
    step_chk("R5 alu1", 4);
    step_chk("R5 alu2", 5);
    step_chk("R5 alu back to fetch", 0);
  endtask

  task automatic t_busy_alui();
    opcode_i = 5'b00100;
    busy_i = 1'b1;               // ignored on the advance step
    step_chk("R3 busy ignored on next", 1);
    cond_i = 1'b1;               // cond ignored while spinning
    step_chk("R3 spin hold 1", 1);
    step_chk("R3 spin hold 2", 1);
    busy_i = 1'b0;
    step_chk("R3 spin release", 2);
    cond_i = 1'b0;
    step_chk("R4 dispatch alui", 6);
    step_chk("R5 alui1", 7);
    step_chk("R5 alui2", 8);
    step_chk("R5 alui back to fetch", 0);
  endtask

  task automatic t_load();
    fetch_to_dispatch(5'b00000);
    step_chk("R4 dispatch load", 9);
    step_chk("R6 load1", 10);
    step_chk("R6 load2", 11);
    step_chk("R6 load3", 12);
    busy_i = 1'b1;
    step_chk("R6 load wait 1", 12);
    step_chk("R6 load wait 2", 12);
    busy_i = 1'b0;
    step_chk("R6 load4", 13);
    step_chk("R6 load back to fetch", 0);
  endtask

  task automatic t_jal();
    fetch_to_dispatch(5'b11011);
    busy_i = 1'b1;
    cond_i = 1'b1;
    step_chk("R4 dispatch jal busy ignored", 14);
    step_chk("R7 jal1", 15);
    step_chk("R7 jal2", 16);
    step_chk("R7 jal back to fetch", 0);
    busy_i = 1'b0;
    cond_i = 1'b0;
  endtask

  task automatic t_branch(input bit taken);
    fetch_to_dispatch(5'b11000);
    step_chk("R4 dispatch branch", 17);
    cond_i = 1'b1;               // no effect on advance step
    step_chk("R8 br1 cond ignored", 18);
    cond_i = 1'b0;
    step_chk("R8 br2", 19);
    cond_i = taken;
    busy_i = 1'b1;               // no effect on the test step
    if (taken) begin
      step_chk("R8 taken continues", 20);
      busy_i = 1'b0;
      cond_i = 1'b0;
      step_chk("R8 taken 2", 21);
      step_chk("R8 taken 3", 22);
      step_chk("R8 taken back to fetch", 0);
    end else begin
      step_chk("R8 not taken to fetch", 0);
      busy_i = 1'b0;
    end
    cond_i = 1'b0;
  endtask

  task automatic t_mma();
    fetch_to_dispatch(5'b00010);
    step_chk("R4 dispatch mma", 23);
    step_chk("R9 mma1", 24);
    busy_i = 1'b1;
    cond_i = 1'b1;
    step_chk("R9 mma wait a", 24);
    busy_i = 1'b0;
    step_chk("R9 mma2", 25);
    step_chk("R9 mma3", 26);
    busy_i = 1'b1;
    step_chk("R9 mma wait b1", 26);
    step_chk("R9 mma wait b2", 26);
    busy_i = 1'b0;
    step_chk("R9 mma4", 27);
    step_chk("R9 mma5", 28);
    chk("R11 ctrl mem write", int'(ctrl_o), 16'h0013);
    busy_i = 1'b1;
    step_chk("R9 mma wait w", 28);
    busy_i = 1'b0;
    step_chk("R9 mma6", 29);
    step_chk("R9 mma back to fetch", 0);
    cond_i = 1'b0;
  endtask

  task automatic t_trap();
    fetch_to_dispatch(5'b11111);
    step_chk("R10 undefined to trap", 31);
    chk("R10 trap flag", int'(trap_o), 1);
    busy_i = 1'b1;
    cond_i = 1'b1;
    opcode_i = 5'b01100;
    for (int k = 0; k < 4; k++) step_chk("R10 trap holds", 31);
    chk("R10 trap still set", int'(trap_o), 1);
    busy_i = 1'b0;
    cond_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk("R10 reset leaves trap upc", int'(upc_o), 0);
    chk("R10 reset clears trap", int'(trap_o), 0);
    tick();
    rst_ni = 1'b1;
  endtask

  initial begin
    t_reset();
    t_alu();
    t_busy_alui();
    t_load();
    t_jal();
    t_branch(1'b0);
    t_branch(1'b1);
    t_mma();
    t_trap();
    t_alu();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule